// File: doc/BRIEF.md
# Selectable Periodic Interrupt Generator

This block turns a 256 Hz timebase tick into a periodic event whose rate software picks through a 3-bit select field in an 8-bit control byte. Each time the internal divider completes a period, a sticky periodic flag is set. The flag drives an interrupt line for as long as the select field holds a valid rate. Software acknowledges an event by writing the control byte with the flag bit at zero. Writing a zero select together with a zero flag bit turns the function off completely.

The divider advances only on timebase ticks. It restarts from zero whenever software writes a select value different from the current one, so the first event after a rate change arrives one full new period later. A write that repeats the current select value leaves the divider running. Calendar counting and alarm matching are handled elsewhere. The tick input is a single-cycle pulse at 256 Hz.

Top module: `periodic_irq_gen`

## Requirements
- R1: After synchronous reset, the read-back byte is 0x00 and `per_irq` is low.
- R2: The control byte holds the select field in bits 6:4 and the periodic flag in bit 7. A write loads bits 6:4 into the select field. The read-back byte shows the flag in bit 7, the select field in bits 6:4, and zero in bits 3:0.
- R3: Select codes give these periods, counted in ticks: 1 gives 1 tick (256 Hz), 2 gives 4 ticks (64 Hz), 3 gives 16 ticks (16 Hz), 4 gives 64 ticks (4 Hz), 5 gives 128 ticks (2 Hz), 6 gives 256 ticks (1 Hz).
- R4: Select code 0, and the reserved code 7, produce no events; the flag never sets while either is selected.
- R5: The flag sets on the clock edge at which the tick that completes a period is sampled. Once set, it stays set until software clears it.
- R6: A write with bit 7 = 0 clears the flag, and a write with bit 7 = 1 leaves it unchanged. If a period completes on the same edge as a clearing write, the flag is set. Writing 0x00 clears the flag and stops all events.
- R7: `per_irq` is high exactly when the flag is set and the select field holds a code from 1 to 6. With code 0 or 7, a set flag stays visible in bit 7 but raises no interrupt.
- R8: A write whose select value differs from the current one restarts the divider, so the first event follows a full period of the new rate. A write with the same select value does not disturb the count, and a write with a new select value takes no period completion on that edge.
- R9: The divider advances only on cycles with `tick_256` high. Idle cycles between ticks do not change when events occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_256 | input | 1 | Single-cycle 256 Hz timebase pulse |
| reg_we | input | 1 | Control byte write strobe |
| reg_wdata | input | DATA_W | Control byte write data |
| reg_rdata | output | DATA_W | Control byte read-back (flag, select, zeros) |
| per_irq | output | 1 | Periodic interrupt request |

## Verification
The bench counts the events for every valid code across 512 ticks, with idle cycles between the ticks. A wrong period decode or a divider that counts clocks instead of ticks changes that count. It sets the flag and then selects codes 0 and 7: a design that gates the interrupt only on a nonzero select, or that keeps counting on the reserved code, raises `per_irq` or sets the flag in those windows. It also puts a clearing write on the same edge as a period completion, where a design with the wrong priority loses the event. Finally, it writes a new rate in the middle of a period and then repeats the current rate in the middle of a period. A design without the restart, or one that restarts on every write, fires early in the first case or late in the second.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

    localparam int BASE_HZ = 256;
    localparam int CNT_W   = $clog2(BASE_HZ);

    typedef enum logic [2:0] {
        RATE_OFF  = 3'd0,
        RATE_256  = 3'd1,
        RATE_64   = 3'd2,
        RATE_16   = 3'd3,
        RATE_4    = 3'd4,
        RATE_2    = 3'd5,
        RATE_1    = 3'd6,
        RATE_RSVD = 3'd7
    } rate_sel_e;

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] last;
    } rate_cfg_t;

    // Period length is a power of two; return the last count of the period.
    function automatic rate_cfg_t decode_rate(rate_sel_e s);
        rate_cfg_t c;
        int        k;
        c.active = 1'b1;
        case (s)
            RATE_256: k = 0;
            RATE_64:  k = 2;
            RATE_16:  k = 4;
            RATE_4:   k = 6;
            RATE_2:   k = 7;
            RATE_1:   k = 8;
            default: begin
                k        = 0;
                c.active = 1'b0;
            end
        endcase
        c.last = CNT_W'((1 << k) - 1);
        return c;
    endfunction

endpackage

// File: rtl/pirq_rate_decode.sv
module pirq_rate_decode
    import pirq_pkg::*;
(
    input  rate_sel_e sel,
    output rate_cfg_t cfg
);
    always_comb cfg = decode_rate(sel);
endmodule

// File: rtl/pirq_divider.sv
module pirq_divider
    import pirq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      restart,
    input  rate_cfg_t cfg,
    output logic      wrap
);
    logic [CNT_W-1:0] cnt_q;

    assign wrap = tick && cfg.active && !restart && (cnt_q == cfg.last);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (restart || !cfg.active) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= (cnt_q == cfg.last) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pirq_flag.sv
module pirq_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/periodic_irq_gen.sv
module periodic_irq_gen
    import pirq_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int SEL_LSB  = 4,
    parameter int FLAG_BIT = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_256,
    input  logic              reg_we,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              per_irq
);
    localparam int SEL_W = $bits(rate_sel_e);
    localparam logic [DATA_W-1:0] USED_MASK =
        DATA_W'((1 << FLAG_BIT) | (((1 << SEL_W) - 1) << SEL_LSB));

    rate_sel_e sel_q;
    rate_sel_e wsel;
    rate_cfg_t cfg;
    logic      restart;
    logic      wrap;
    logic      flag;
    logic      unused_wbits;

    assign wsel         = rate_sel_e'(reg_wdata[SEL_LSB +: SEL_W]);
    assign restart      = reg_we && (wsel != sel_q);
    assign unused_wbits = ^(reg_wdata & ~USED_MASK);

    always_ff @(posedge clk) begin
        if (rst)         sel_q <= RATE_OFF;
        else if (reg_we) sel_q <= wsel;
    end

    pirq_rate_decode u_dec (
        .sel (sel_q),
        .cfg (cfg)
    );

    pirq_divider u_div (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_256),
        .restart (restart),
        .cfg     (cfg),
        .wrap    (wrap)
    );

    pirq_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (wrap),
        .clr_i  (reg_we && !reg_wdata[FLAG_BIT]),
        .flag_o (flag)
    );

    always_comb begin
        reg_rdata                    = '0;
        reg_rdata[FLAG_BIT]          = flag;
        reg_rdata[SEL_LSB +: SEL_W]  = sel_q;
    end

    assign per_irq = flag && cfg.active;
endmodule

// File: rtl/periodic_irq_gen_chk.sv
module periodic_irq_gen_chk #(
    parameter int DATA_W   = 8,
    parameter int SEL_LSB  = 4,
    parameter int FLAG_BIT = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              tick_256,
    input logic              reg_we,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [DATA_W-1:0] reg_rdata,
    input logic              per_irq
);
    localparam logic [DATA_W-1:0] USED_MASK =
        DATA_W'((1 << FLAG_BIT) | (7 << SEL_LSB));

    logic [2:0] sel_rd;
    logic       off_rd;
    assign sel_rd = reg_rdata[SEL_LSB +: 3];
    assign off_rd = (sel_rd == 3'd0) || (sel_rd == 3'd7);

    // R2: unused bits read as zero
    a_r2_low_bits_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata & ~USED_MASK) == '0);

    // R2: a write loads the select field
    a_r2_sel_load: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> sel_rd == $past(reg_wdata[SEL_LSB +: 3]));

    // R7: interrupt needs a set flag and a valid code
    a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
        per_irq |-> (reg_rdata[FLAG_BIT] && !off_rd));

    // R4: no event while off or reserved
    a_r4_no_set_when_off: assert property (@(posedge clk) disable iff (rst)
        (off_rd && !reg_rdata[FLAG_BIT]) |=> !reg_rdata[FLAG_BIT]);

    // R5 / R9: the flag only rises after a tick
    a_r5_set_needs_tick: assert property (@(posedge clk) disable iff (rst)
        (!reg_rdata[FLAG_BIT] && !tick_256) |=> !reg_rdata[FLAG_BIT]);

    // R5: a set flag holds without a write
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (reg_rdata[FLAG_BIT] && !reg_we) |=> reg_rdata[FLAG_BIT]);

    // R6: a clearing write without a tick clears the flag
    a_r6_clear: assert property (@(posedge clk) disable iff (rst)
        (reg_we && !reg_wdata[FLAG_BIT] && !tick_256) |=> !reg_rdata[FLAG_BIT]);
endmodule

bind periodic_irq_gen periodic_irq_gen_chk #(
    .DATA_W   (DATA_W),
    .SEL_LSB  (SEL_LSB),
    .FLAG_BIT (FLAG_BIT)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick_256  (tick_256),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .per_irq   (per_irq)
);

// File: tb/periodic_irq_gen_tb.sv
module periodic_irq_gen_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_256 = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       per_irq;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    string tag = "R1";

    // reference model state
    int m_sel  = 0;
    int m_cnt  = 0;
    bit m_flag = 0;

    always #2.5 clk = ~clk;

    periodic_irq_gen u_dut (
        .clk       (clk),
        .rst       (rst),
        .tick_256  (tick_256),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .per_irq   (per_irq)
    );

    function automatic int period_of(int s);
        case (s)
            1: return 1;
            2: return 4;
            3: return 16;
            4: return 64;
            5: return 128;
            6: return 256;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_sel = 0; m_cnt = 0; m_flag = 0;
        end else begin
            int  p;
            int  nsel;
            bit  chg;
            bit  wrap;
            p    = period_of(m_sel);
            nsel = int'(reg_wdata[6:4]);
            chg  = reg_we && (nsel != m_sel);
            wrap = 0;
            if (chg || p == 0) m_cnt = 0;
            else if (tick_256) begin
                m_cnt = m_cnt + 1;
                if (m_cnt == p) begin
                    m_cnt = 0;
                    wrap  = 1;
                end
            end
            if (wrap) m_flag = 1;
            else if (reg_we && !reg_wdata[7]) m_flag = 0;
            if (reg_we) m_sel = nsel;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            int exp_rd;
            bit exp_irq;
            exp_rd  = (int'(m_flag) << 7) | (m_sel << 4);
            exp_irq = m_flag && (period_of(m_sel) != 0);
            check(int'(reg_rdata) == exp_rd, {tag, " R2 read-back"}, int'(reg_rdata), exp_rd);
            check(per_irq == exp_irq, {tag, " R7 irq"}, int'(per_irq), int'(exp_irq));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 150000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    task automatic step(bit t, bit we, logic [7:0] d);
        @(negedge clk);
        tick_256  = t;
        reg_we    = we;
        reg_wdata = d;
    endtask

    task automatic idle();
        step(0, 0, 8'h00);
    endtask

    // run ticks until the flag shows, return the tick count (limit 600)
    task automatic ticks_to_flag(output int n);
        n = 0;
        do begin
            step(1, 0, 8'h00);
            idle();
            n++;
        end while (!reg_rdata[7] && n < 600);
    endtask

    initial begin
        int n;
        int ev;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(reg_rdata == 8'h00, "R1 rdata after reset", int'(reg_rdata), 0);
        check(per_irq == 1'b0, "R1 irq after reset", int'(per_irq), 0);
        @(negedge clk);
        rst = 1'b0;
        idle(); idle();

        // R2: low bits are ignored, fields read back
        tag = "R2";
        step(0, 1, 8'h3F);
        idle();
        check(reg_rdata == 8'h30, "R2 field read-back", int'(reg_rdata), 8'h30);

        // R3 / R9: event counts over 512 ticks with gaps between ticks
        tag = "R3";
        for (int s = 1; s <= 6; s++) begin
            step(0, 1, 8'(s << 4));
            ev = 0;
            for (int i = 0; i < 512; i++) begin
                step(1, 0, 8'h00);
                idle();
                if (reg_rdata[7]) begin
                    ev++;
                    step(0, 1, 8'(s << 4));
                    idle();
                end
            end
            check(ev == 512 / period_of(s), "R3 R9 event count", ev, 512 / period_of(s));
        end

        // R4: code 0 and reserved code 7 make no events
        tag = "R4";
        step(0, 1, 8'h00);
        repeat (300) begin step(1, 0, 8'h00); idle(); end
        check(reg_rdata[7] == 1'b0, "R4 code 0 no flag", int'(reg_rdata[7]), 0);
        step(0, 1, 8'h70);
        repeat (300) begin step(1, 0, 8'h00); idle(); end
        check(reg_rdata[7] == 1'b0, "R4 code 7 no flag", int'(reg_rdata[7]), 0);

        // R5 / R7: flag sets after a tick and raises irq; it holds
        tag = "R5";
        step(0, 1, 8'h10);
        step(1, 0, 8'h00);
        idle();
        check(reg_rdata[7] == 1'b1, "R5 flag set", int'(reg_rdata[7]), 1);
        check(per_irq == 1'b1, "R7 irq with valid code", int'(per_irq), 1);
        repeat (5) idle();
        check(reg_rdata[7] == 1'b1, "R5 flag sticky", int'(reg_rdata[7]), 1);

        // R7 / R6: bit7=1 keeps the flag, code 0 masks irq
        tag = "R7";
        step(0, 1, 8'h80);
        idle();
        check(reg_rdata[7] == 1'b1, "R6 write 1 keeps flag", int'(reg_rdata[7]), 1);
        check(per_irq == 1'b0, "R7 irq masked by code 0", int'(per_irq), 0);
        step(0, 1, 8'hF0);
        idle();
        check(per_irq == 1'b0, "R7 irq masked by code 7", int'(per_irq), 0);
        step(0, 1, 8'h00);
        idle();
        check(reg_rdata == 8'h00, "R6 write 0x00 all off", int'(reg_rdata), 0);

        // R6: period completion wins over a clearing write
        tag = "R6";
        step(0, 1, 8'h10);
        step(1, 1, 8'h10);
        idle();
        check(reg_rdata[7] == 1'b1, "R6 set beats clear", int'(reg_rdata[7]), 1);
        step(0, 1, 8'h10);
        idle();
        check(reg_rdata[7] == 1'b0, "R6 clear", int'(reg_rdata[7]), 0);

        // R8: new rate restarts; same rate does not
        tag = "R8";
        step(0, 1, 8'h30);
        repeat (10) begin step(1, 0, 8'h00); idle(); end
        step(0, 1, 8'h20);
        ticks_to_flag(n);
        check(n == 4, "R8 restart on new rate", n, 4);
        step(0, 1, 8'h20);
        repeat (2) begin step(1, 0, 8'h00); idle(); end
        step(0, 1, 8'hA0);
        ticks_to_flag(n);
        check(n == 2, "R8 same rate keeps count", n, 2);
        step(0, 1, 8'h20);
        step(1, 1, 8'h30);
        idle();
        check(reg_rdata[7] == 1'b0, "R8 no completion on rate change", int'(reg_rdata[7]), 0);
        ticks_to_flag(n);
        check(n == 16, "R8 full period after change", n, 16);

        idle(); idle();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule